// File: doc/BRIEF.md
# SHA-256 Message Schedule Window Stage

This stage produces the sixty-four expanded message words of one SHA-256 block, one word per round. It holds the sixteen most recent words in a window of registers. A load strobe fills the window with the sixteen words of a fresh 512-bit block. Each advance then drops the oldest word and appends a newly derived word at the top.

The new word is formed from four taps of the current window: the base word, the small sigma-0 of the next word, the word nine places up, and the small sigma-1 of the word fourteen places up. The sum is built in two stages. A three-input adder takes the first three terms, and a two-input adder then adds the sigma-1 term. The result is captured into the top slot on the advancing edge.

The round logic reads the base of the window as the current word. Because of this, words 0 through 63 appear on the current-word output one per advance after a load.

Top module: `msg_sched_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every window slot is cleared to zero after that edge, so `window_o` and `cur_word_o` read zero.
- R2: A rising edge with `load_i` high copies `blk_i` into the window. Block word k sits at bits [32k+31:32k] of both `blk_i` and `window_o`. Word 0 is the base and appears on `cur_word_o`.
- R3: A rising edge with `adv_i` high and `load_i` low moves every slot down by one place: slot k takes the old slot k+1.
- R4: On such an advance, slot 15 takes base + σ0(slot 1) + slot 9 + σ1(slot 14), all evaluated on the window before the edge. The new value is visible in the cycle right after that edge.
- R5: σ0(x) = rotr7(x) ^ rotr18(x) ^ shr3(x), and σ1(x) = rotr17(x) ^ rotr19(x) ^ shr10(x). For example, σ0(1) = 0x02004000 and σ1(1) = 0x0000A000.
- R6: All additions wrap modulo 2^32. For example, 0xFFFFFFFF + 1 gives 0.
- R7: An edge with both `load_i` and `adv_i` low leaves the whole window unchanged.
- R8: When `load_i` and `adv_i` are both high on one edge, the load wins and the advance has no effect.
- R9: After a load, `cur_word_o` shows SHA-256 schedule words w[0]..w[63] on successive advances. This holds even when idle cycles fall between the advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load the window from `blk_i` |
| adv_i | input | 1 | Advance the window by one word |
| blk_i | input | 512 | Block words, word k at bits [32k+31:32k] |
| cur_word_o | output | 32 | Window base, the word for the current round |
| window_o | output | 512 | Whole window, slot k at bits [32k+31:32k] |

## Verification
Loading a block and advancing the window are the two functions that can land on the same edge. The bench raises `load_i` and `adv_i` together partway through a running schedule. It judges the result by comparing the whole window after that edge with the new block, and by checking that no slot moved and that nothing was appended. The bound checker checks the same priority on every edge. After a load, its load property must hold whatever `adv_i` was.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  localparam int WORD_W    = 32;
  localparam int WIN_DEPTH = 16;
  localparam int BLK_W     = WORD_W * WIN_DEPTH;
  localparam int TAP_BASE  = 0;
  localparam int TAP_LO    = 1;
  localparam int TAP_MID   = 9;
  localparam int TAP_HI    = 14;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [WIN_DEPTH-1:0][WORD_W-1:0] win_t;

  function automatic word_t rot_right(word_t x, int unsigned n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[WORD_W-1:0];
  endfunction

  function automatic word_t small_sigma_lo(word_t x);
    return rot_right(x, 7) ^ rot_right(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sigma_hi(word_t x);
    return rot_right(x, 17) ^ rot_right(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sched_sigma.sv
module sched_sigma
  import msg_sched_pkg::*;
#(
  parameter bit HIGH = 1'b0
) (
  input  word_t x_i,
  output word_t y_o
);
  generate
    if (HIGH) begin : g_hi
      assign y_o = small_sigma_hi(x_i);
    end else begin : g_lo
      assign y_o = small_sigma_lo(x_i);
    end
  endgenerate
endmodule

// File: rtl/sched_sum.sv
module sched_sum
  import msg_sched_pkg::*;
(
  input  word_t base_i,
  input  word_t lo_sig_i,
  input  word_t mid_i,
  input  word_t hi_sig_i,
  output word_t part_o,
  output word_t sum_o
);
  // stage one: three operands share one carry chain
  assign part_o = base_i + lo_sig_i + mid_i;
  // stage two: late sigma-1 term joins last
  assign sum_o  = part_o + hi_sig_i;
endmodule

// File: rtl/sched_window.sv
module sched_window
  import msg_sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  adv_i,
  input  win_t  blk_i,
  input  word_t top_i,
  output win_t  slots_o
);
  genvar k;
  generate
    for (k = 0; k < WIN_DEPTH; k++) begin : g_slot
      word_t q;
      word_t shift_in;
      if (k == WIN_DEPTH - 1) begin : g_top
        assign shift_in = top_i;
      end else begin : g_mid
        assign shift_in = slots_o[k+1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load_i) q <= blk_i[k];
        else if (adv_i)  q <= shift_in;
      end
      assign slots_o[k] = q;
    end
  endgenerate
endmodule

// File: rtl/msg_sched_stage.sv
module msg_sched_stage
  import msg_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [WORD_W-1:0] cur_word_o,
  output logic [BLK_W-1:0] window_o
);
  win_t  blk_w;
  win_t  slots;
  word_t lo_sig;
  word_t hi_sig;
  word_t part_sum;
  word_t next_word;

  assign blk_w = blk_i;

  sched_window u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_i  (adv_i),
    .blk_i  (blk_w),
    .top_i  (next_word),
    .slots_o(slots)
  );

  sched_sigma #(.HIGH(1'b0)) u_sig_lo (.x_i(slots[TAP_LO]), .y_o(lo_sig));
  sched_sigma #(.HIGH(1'b1)) u_sig_hi (.x_i(slots[TAP_HI]), .y_o(hi_sig));

  sched_sum u_sum (
    .base_i  (slots[TAP_BASE]),
    .lo_sig_i(lo_sig),
    .mid_i   (slots[TAP_MID]),
    .hi_sig_i(hi_sig),
    .part_o  (part_sum),
    .sum_o   (next_word)
  );

  assign cur_word_o = slots[TAP_BASE];
  assign window_o   = slots;
endmodule

// File: rtl/msg_sched_checker.sv
module msg_sched_checker
  import msg_sched_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              adv_i,
  input logic [BLK_W-1:0]  blk_i,
  input logic [WORD_W-1:0] cur_word_o,
  input logic [BLK_W-1:0]  window_o,
  input logic [WORD_W-1:0] next_word
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (window_o == '0));

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (window_o == $past(blk_i)));

  assert_base_is_cur_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur_word_o == $past(blk_i[WORD_W-1:0])));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (window_o[BLK_W-WORD_W-1:0] == $past(window_o[BLK_W-1:WORD_W])));

  assert_top_from_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (window_o[BLK_W-1 -: WORD_W] == $past(next_word)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(window_o));

  // R8: load with advance still yields exactly the block
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (window_o == $past(blk_i)));
endmodule

bind msg_sched_stage msg_sched_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .adv_i     (adv_i),
  .blk_i     (blk_i),
  .cur_word_o(cur_word_o),
  .window_o  (window_o),
  .next_word (next_word)
);

// File: tb/msg_sched_stage_test.sv
module msg_sched_stage_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic         adv_i;
  logic [511:0] blk_i;
  logic [31:0]  cur_word_o;
  logic [511:0] window_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msg_sched_stage uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .blk_i(blk_i), .cur_word_o(cur_word_o), .window_o(window_o)
  );

  // stimulus table: block seed and whether idle gaps separate advances
  localparam int N_VEC = 5;
  localparam logic [31:0] SEEDS [N_VEC] = '{32'h1234_5678, 32'hDEAD_BEEF,
                                           32'h0BAD_F00D, 32'h7FFF_0001, 32'hC001_D00D};
  localparam bit GAPS [N_VEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] ref_s0(logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] ref_s1(logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [511:0] make_block(logic [31:0] seed);
    logic [31:0] s;
    logic [511:0] b;
    s = seed;
    for (int k = 0; k < 16; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      b[32*k +: 32] = s;
    end
    return b;
  endfunction

  logic [31:0] wref [64];

  task automatic build_ref(logic [511:0] b);
    for (int t = 0; t < 64; t++) begin
      if (t < 16) wref[t] = b[32*t +: 32];
      else wref[t] = ref_s1(wref[t-2]) + wref[t-7] + ref_s0(wref[t-15]) + wref[t-16];
    end
  endtask

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk512(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change at a falling edge; outputs read at the next falling edge
  task automatic cycle(logic l, logic a, logic [511:0] b);
    load_i = l; adv_i = a; blk_i = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [511:0] blk;
    logic [511:0] prev;
    rst_n = 1'b0; load_i = 1'b0; adv_i = 1'b0; blk_i = '0;
    @(negedge clk);
    cycle(1'b0, 1'b1, {16{32'hA5A5_5A5A}});
    chk512("R1 reset window", window_o, '0);
    chk32("R1 reset cur", cur_word_o, 32'h0);
    rst_n = 1'b1;

    for (int e = 0; e < N_VEC; e++) begin
      blk = make_block(SEEDS[e]);
      build_ref(blk);
      cycle(1'b1, 1'b0, blk);
      chk512("R2 load window", window_o, blk);
      chk32("R9 word 0", cur_word_o, wref[0]);
      for (int i = 1; i < 64; i++) begin
        if (GAPS[e] && (i % 3 == 0)) begin
          prev = window_o;
          cycle(1'b0, 1'b0, ~blk);
          chk512("R7 idle hold", window_o, prev);
        end
        prev = window_o;
        cycle(1'b0, 1'b1, ~blk);
        chk32($sformatf("R9 word %0d", i), cur_word_o, wref[i]);
        if (i == 1) chk512("R3 shift down", {32'h0, window_o[479:0]}, {32'h0, prev[511:32]});
        if (i <= 48) chk32($sformatf("R4 top word %0d", i + 15), window_o[511:480], wref[i+15]);
      end
    end

    // R5: sigma-0 alone, block word1 = 1
    cycle(1'b1, 1'b0, 512'h1 << 32);
    cycle(1'b0, 1'b1, '0);
    chk32("R5 sigma0 of one", window_o[511:480], 32'h0200_4000);
    // R5: sigma-1 alone, block word14 = 1
    cycle(1'b1, 1'b0, 512'h1 << 448);
    cycle(1'b0, 1'b1, '0);
    chk32("R5 sigma1 of one", window_o[511:480], 32'h0000_A000);
    // R6: word0 all ones plus word9 = 1 wraps to zero
    cycle(1'b1, 1'b0, (512'h1 << 288) | 512'hFFFF_FFFF);
    cycle(1'b0, 1'b1, '0);
    chk32("R6 wrap to zero", window_o[511:480], 32'h0);
    // R6: all-ones block against the reference
    blk = {512{1'b1}};
    build_ref(blk);
    cycle(1'b1, 1'b0, blk);
    cycle(1'b0, 1'b1, '0);
    chk32("R6 all ones top", window_o[511:480], wref[16]);

    // R8: load and advance together mid-sequence
    blk = make_block(32'h5555_AAAA);
    cycle(1'b1, 1'b0, make_block(32'h0F0F_1111));
    cycle(1'b0, 1'b1, '0);
    cycle(1'b0, 1'b1, '0);
    cycle(1'b1, 1'b1, blk);
    chk512("R8 load beats advance", window_o, blk);
    chk32("R8 base after collision", cur_word_o, blk[31:0]);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    cycle(1'b1, 1'b1, make_block(32'h9999_0000));
    chk512("R1 mid-run reset", window_o, '0);
    rst_n = 1'b1;
    cycle(1'b0, 1'b0, '0);
    chk32("R1 stays clear", cur_word_o, 32'h0);

    finish_run();
  end
endmodule